// File: doc/BRIEF.md
# Transform Accelerator Network Wrapper

The wrapper sits between a transform pipeline (forward transform, quantizer, inverse transform) and a FIFO-style on-chip network. It reads a job request from the receive FIFO. A request is an address-flagged header word followed by data words in a fixed order: the return address for quantized results, the return address for reconstructed results, a control word, and then 192 data words. Those data words carry 384 signed 16-bit samples, which make up six 8x8 blocks. The samples go to the pipeline two per cycle. At the start of each block the wrapper also loads a set of block parameters: quantizer step, intra flag, and a colour-difference flag.

Results come back on two valid/ready streams. The wrapper packs them two values per network word. It sends each block's quantized values to the first return address, then that block's reconstructed values to the second, and repeats this for all six blocks. When the last block is done it sends a coded-block pattern word to the quantized-result address. It then sends a release message to a fixed requester address. Until that release goes out, any further request words are read and dropped.

Top module: `trn_accel_wrap`

## Requirements
- R1: While reset is held, txWe, smpValid, parLoad, qReady and iReady are 0, and rxRe always equals the inverse of rxEmpty.
- R2: After a header word (rxAv=1), the first data word (rxAv=0) is the quantized-result address, the second is the reconstructed-result address and the third is the control word. In the control word, bits 4:0 are the quantizer step, bit 5 is the intra flag and the other bits are zero.
- R3: The next 192 data words are forwarded unchanged on smpData, one cycle after they are read. Within each word, the lower-indexed sample is in bits 15:0.
- R4: On the first sample word of each block b (b = 0..5), parLoad is asserted together with smpValid. It carries the captured step and intra flag, and parChroma = 1 exactly for b = 4 and b = 5.
- R5: Each output burst is an address word followed by 32 data words. The address word has txAv=1, txComm=00010 and carries the return address. The data words have txAv=0 and txComm=00010. Bursts alternate, quantized first, one quantized and one reconstructed burst per block.
- R6: Each result word packs two values, with the earlier value in bits 15:0. A quantized value (12 bits) is sign-extended, except coefficient 0 of a block in an intra job, which is zero-extended. Reconstructed values (9 bits) are sign-extended.
- R7: After the last reconstructed burst, the wrapper sends an address word to the quantized-result address and then one data word. In that word, bit j is 1 when block j has a nonzero quantized value, ignoring coefficient 0 in intra jobs. All higher bits are 0.
- R8: The job ends with an address word to the release address 0x00000F00, then a data word holding the wrapper's own address 0x03000000.
- R9: While txFull is high, a pending word keeps txWe, txAv and txData unchanged, and no result value is accepted.
- R10: Request words that arrive before the release message has been sent are consumed and produce no samples or parameter loads. After the release, a new request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rxData | input | 32 | Receive FIFO head word |
| rxAv | input | 1 | Head word is an address word |
| rxEmpty | input | 1 | Receive FIFO empty |
| rxRe | output | 1 | Receive FIFO read enable |
| txData | output | 32 | Transmit word |
| txAv | output | 1 | Transmit word is an address word |
| txComm | output | 5 | Transmit command code |
| txWe | output | 1 | Transmit write enable |
| txFull | input | 1 | Transmit FIFO full |
| smpValid | output | 1 | Sample pair valid |
| smpData | output | 32 | Two samples, lower index in bits 15:0 |
| parLoad | output | 1 | Block parameter load strobe |
| parQp | output | 5 | Quantizer step |
| parIntra | output | 1 | Intra flag |
| parChroma | output | 1 | Colour-difference block flag |
| qValid | input | 1 | Quantized value valid |
| qData | input | 12 | Quantized value |
| qReady | output | 1 | Quantized value accepted this cycle |
| iValid | input | 1 | Reconstructed value valid |
| iData | input | 9 | Reconstructed value |
| iReady | output | 1 | Reconstructed value accepted this cycle |

## Verification
The assertions rely on two assumptions about the environment. First, the pipeline returns exactly 64 values per stream and block, in order. Second, the network side holds txFull steady between clock edges. The stimulus respects both. The model pipeline only offers a block's results after all of that block's samples have been seen. txFull changes only just after a rising edge, following fixed burst patterns. The request stream puts empty gaps inside requests and adds a stray extra request during transmission, which is legal network traffic that the wrapper must tolerate.

// File: rtl/trn_pkg.sv
package trn_pkg;
  localparam int BLK_IDX_W = 3;
  localparam int SMP_W = 16;

  typedef struct packed {
    logic capRetQ;
    logic capRetI;
    logic capCtl;
    logic smpFire;
    logic parLoad;
    logic [BLK_IDX_W-1:0] rxBlk;
    logic ldAddrQ;
    logic ldAddrI;
    logic takeQ;
    logic takeI;
    logic valIdx0;
    logic pairHi;
    logic [BLK_IDX_W-1:0] txBlk;
    logic ldCbpAddr;
    logic ldCbpData;
    logic ldRelAddr;
    logic ldRelData;
  } trnStrobe_t;
endpackage

// File: rtl/trn_ctrl.sv
module trn_ctrl
  import trn_pkg::*;
#(
  parameter int N_BLK  = 6,
  parameter int BLK_SZ = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxPresent,
  input  logic       rxAv,
  input  logic       qValid,
  input  logic       iValid,
  input  logic       slotFree,
  output trnStrobe_t strb,
  output logic       qReady,
  output logic       iReady
);
  localparam int WPB       = BLK_SZ / 2;
  localparam int JOB_WORDS = N_BLK * WPB;
  localparam int WORD_W    = $clog2(JOB_WORDS);
  localparam int WPB_SH    = $clog2(WPB);
  localparam int VAL_W     = $clog2(BLK_SZ);

  typedef enum logic [2:0] {R_IDLE, R_RQ, R_RI, R_CTL, R_SMP, R_WAIT} rxSt_t;
  typedef enum logic [2:0] {T_IDLE, T_ADDR, T_DATA, T_CBPA, T_CBPD, T_RELA, T_RELD} txSt_t;

  rxSt_t rxState;
  txSt_t txState;
  logic [WORD_W-1:0] rxWord;
  logic [VAL_W-1:0] valCnt;
  logic [BLK_IDX_W-1:0] txBlk;
  logic isQuant;
  logic rxDataWord, take, jobDone, jobLive;

  assign rxDataWord = rxPresent && !rxAv;
  assign jobLive    = (rxState == R_SMP) || (rxState == R_WAIT);
  assign jobDone    = (txState == T_RELD) && slotFree;
  assign qReady     = (txState == T_DATA) && isQuant && slotFree;
  assign iReady     = (txState == T_DATA) && !isQuant && slotFree;
  assign take       = (qReady && qValid) || (iReady && iValid);

  always_comb begin
    strb           = '0;
    strb.capRetQ   = (rxState == R_RQ) && rxDataWord;
    strb.capRetI   = (rxState == R_RI) && rxDataWord;
    strb.capCtl    = (rxState == R_CTL) && rxDataWord;
    strb.smpFire   = (rxState == R_SMP) && rxDataWord;
    strb.parLoad   = strb.smpFire && (rxWord[WPB_SH-1:0] == '0);
    strb.rxBlk     = BLK_IDX_W'(rxWord >> WPB_SH);
    strb.ldAddrQ   = (txState == T_ADDR) && slotFree && isQuant;
    strb.ldAddrI   = (txState == T_ADDR) && slotFree && !isQuant;
    strb.takeQ     = qReady && qValid;
    strb.takeI     = iReady && iValid;
    strb.valIdx0   = (valCnt == '0);
    strb.pairHi    = valCnt[0];
    strb.txBlk     = txBlk;
    strb.ldCbpAddr = (txState == T_CBPA) && slotFree;
    strb.ldCbpData = (txState == T_CBPD) && slotFree;
    strb.ldRelAddr = (txState == T_RELA) && slotFree;
    strb.ldRelData = jobDone;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxState <= R_IDLE;
      rxWord  <= '0;
    end else begin
      case (rxState)
        R_IDLE: if (rxPresent && rxAv) rxState <= R_RQ;
        R_RQ:   if (rxDataWord) rxState <= R_RI;
        R_RI:   if (rxDataWord) rxState <= R_CTL;
        R_CTL:  if (rxDataWord) begin
                  rxState <= R_SMP;
                  rxWord  <= '0;
                end
        R_SMP:  if (rxDataWord) begin
                  if (rxWord == WORD_W'(JOB_WORDS - 1)) rxState <= R_WAIT;
                  else rxWord <= rxWord + 1'b1;
                end
        R_WAIT: if (jobDone) rxState <= R_IDLE;
        default: rxState <= R_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txState <= T_IDLE;
      valCnt  <= '0;
      txBlk   <= '0;
      isQuant <= 1'b1;
    end else begin
      case (txState)
        T_IDLE: if (jobLive) begin
                  txState <= T_ADDR;
                  isQuant <= 1'b1;
                  txBlk   <= '0;
                end
        T_ADDR: if (slotFree) begin
                  txState <= T_DATA;
                  valCnt  <= '0;
                end
        T_DATA: if (take) begin
                  valCnt <= valCnt + 1'b1;
                  if (valCnt == VAL_W'(BLK_SZ - 1)) begin
                    isQuant <= !isQuant;
                    if (isQuant) txState <= T_ADDR;
                    else if (txBlk == BLK_IDX_W'(N_BLK - 1)) txState <= T_CBPA;
                    else begin
                      txBlk   <= txBlk + 1'b1;
                      txState <= T_ADDR;
                    end
                  end
                end
        T_CBPA: if (slotFree) txState <= T_CBPD;
        T_CBPD: if (slotFree) txState <= T_RELA;
        T_RELA: if (slotFree) txState <= T_RELD;
        T_RELD: if (slotFree) txState <= T_IDLE;
        default: txState <= T_IDLE;
      endcase
    end
  end

  // R5: the two result streams are never offered together
  a_r5_one_stream: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({qReady, iReady}));

  // R3: the sample word counter stays inside one job
  a_r3_word_bound: assert property (@(posedge clk) disable iff (!rstN)
    (rxState == R_SMP) |-> (rxWord < WORD_W'(JOB_WORDS)));

  // R10: no sample is taken once the job has left the receive phase
  a_r10_busy_drop: assert property (@(posedge clk) disable iff (!rstN)
    (rxState == R_WAIT) |=> !$past(strb.smpFire));

  // R7: the block index used for the pattern bits stays in range
  a_r7_blk_bound: assert property (@(posedge clk) disable iff (!rstN)
    txBlk < BLK_IDX_W'(N_BLK));
endmodule

// File: rtl/trn_dp.sv
module trn_dp
  import trn_pkg::*;
#(
  parameter int DW = 32,
  parameter int QW = 12,
  parameter int RW = 9,
  parameter int QP_W = 5,
  parameter int N_BLK = 6,
  parameter int CHROMA_FIRST = 4,
  parameter int CMD_W = 5,
  parameter logic [CMD_W-1:0] WR_CMD = 5'd2,
  parameter logic [DW-1:0] REL_ADDR = 32'h0000_0F00,
  parameter logic [DW-1:0] SELF_ADDR = 32'h0300_0000
) (
  input  logic             clk,
  input  logic             rstN,
  input  trnStrobe_t       strb,
  input  logic [DW-1:0]    rxData,
  input  logic [QW-1:0]    qData,
  input  logic [RW-1:0]    iData,
  input  logic             txFull,
  output logic             slotFree,
  output logic             smpValid,
  output logic [DW-1:0]    smpData,
  output logic             parLoad,
  output logic [QP_W-1:0]  parQp,
  output logic             parIntra,
  output logic             parChroma,
  output logic             txWe,
  output logic             txAv,
  output logic [CMD_W-1:0] txComm,
  output logic [DW-1:0]    txData
);
  logic [DW-1:0] retQ, retI;
  logic [QP_W-1:0] qpR;
  logic intraR;
  logic [N_BLK-1:0] cbp;
  logic [SMP_W-1:0] lowHalf, valWide, qWide, iWide;
  logic qCounts;

  assign slotFree = !txWe || !txFull;
  assign txComm   = txWe ? WR_CMD : '0;

  always_comb begin
    if (intraR && strb.valIdx0) qWide = SMP_W'(qData);
    else qWide = {{(SMP_W-QW){qData[QW-1]}}, qData};
    iWide   = {{(SMP_W-RW){iData[RW-1]}}, iData};
    valWide = strb.takeQ ? qWide : iWide;
    qCounts = strb.takeQ && (qData != '0) && !(intraR && strb.valIdx0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      retQ <= '0; retI <= '0; qpR <= '0; intraR <= 1'b0; cbp <= '0;
      smpValid <= 1'b0; smpData <= '0;
      parLoad <= 1'b0; parQp <= '0; parIntra <= 1'b0; parChroma <= 1'b0;
      lowHalf <= '0;
    end else begin
      if (strb.capRetQ) retQ <= rxData;
      if (strb.capRetI) retI <= rxData;
      if (strb.capCtl) begin
        qpR    <= rxData[QP_W-1:0];
        intraR <= rxData[QP_W];
        cbp    <= '0;
      end else if (qCounts) begin
        cbp[strb.txBlk] <= 1'b1;
      end
      smpValid <= strb.smpFire;
      if (strb.smpFire) smpData <= rxData;
      parLoad <= strb.parLoad;
      if (strb.parLoad) begin
        parQp     <= qpR;
        parIntra  <= intraR;
        parChroma <= (int'(strb.rxBlk) >= CHROMA_FIRST);
      end
      if ((strb.takeQ || strb.takeI) && !strb.pairHi) lowHalf <= valWide;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txWe <= 1'b0; txAv <= 1'b0; txData <= '0;
    end else if (strb.ldAddrQ || strb.ldCbpAddr) begin
      txWe <= 1'b1; txAv <= 1'b1; txData <= retQ;
    end else if (strb.ldAddrI) begin
      txWe <= 1'b1; txAv <= 1'b1; txData <= retI;
    end else if (strb.ldRelAddr) begin
      txWe <= 1'b1; txAv <= 1'b1; txData <= REL_ADDR;
    end else if ((strb.takeQ || strb.takeI) && strb.pairHi) begin
      txWe <= 1'b1; txAv <= 1'b0; txData <= DW'({valWide, lowHalf});
    end else if (strb.ldCbpData) begin
      txWe <= 1'b1; txAv <= 1'b0; txData <= DW'(cbp);
    end else if (strb.ldRelData) begin
      txWe <= 1'b1; txAv <= 1'b0; txData <= SELF_ADDR;
    end else if (txWe && !txFull) begin
      txWe <= 1'b0;
    end
  end

  // R9: a pending word is frozen while the network is full
  a_r9_hold_full: assert property (@(posedge clk) disable iff (!rstN)
    (txWe && txFull) |=> (txWe && $stable(txData) && $stable(txAv)));

  // R4: a parameter load always accompanies a sample word
  a_r4_par_with_smp: assert property (@(posedge clk) disable iff (!rstN)
    parLoad |-> smpValid);

  // R7: pattern word carries nothing above the block bits
  a_r7_cbp_clean: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.ldCbpData) |-> (txData[DW-1:N_BLK] == '0));

  // R5: address words only appear when an address load was issued
  a_r5_addr_src: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txAv) |-> $past(strb.ldAddrQ || strb.ldAddrI || strb.ldCbpAddr || strb.ldRelAddr));
endmodule

// File: rtl/trn_accel_wrap.sv
module trn_accel_wrap
  import trn_pkg::*;
#(
  parameter int DW = 32,
  parameter int QW = 12,
  parameter int RW = 9,
  parameter int QP_W = 5,
  parameter int N_BLK = 6,
  parameter int BLK_SZ = 64,
  parameter int CHROMA_FIRST = 4,
  parameter int CMD_W = 5,
  parameter logic [CMD_W-1:0] WR_CMD = 5'd2,
  parameter logic [DW-1:0] REL_ADDR = 32'h0000_0F00,
  parameter logic [DW-1:0] SELF_ADDR = 32'h0300_0000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DW-1:0]    rxData,
  input  logic             rxAv,
  input  logic             rxEmpty,
  output logic             rxRe,
  output logic [DW-1:0]    txData,
  output logic             txAv,
  output logic [CMD_W-1:0] txComm,
  output logic             txWe,
  input  logic             txFull,
  output logic             smpValid,
  output logic [DW-1:0]    smpData,
  output logic             parLoad,
  output logic [QP_W-1:0]  parQp,
  output logic             parIntra,
  output logic             parChroma,
  input  logic             qValid,
  input  logic [QW-1:0]    qData,
  output logic             qReady,
  input  logic             iValid,
  input  logic [RW-1:0]    iData,
  output logic             iReady
);
  trnStrobe_t strb;
  logic slotFree;

  assign rxRe = !rxEmpty;

  trn_ctrl #(.N_BLK(N_BLK), .BLK_SZ(BLK_SZ)) ctrl_i (
    .clk(clk), .rstN(rstN), .rxPresent(!rxEmpty), .rxAv(rxAv),
    .qValid(qValid), .iValid(iValid), .slotFree(slotFree),
    .strb(strb), .qReady(qReady), .iReady(iReady));

  trn_dp #(.DW(DW), .QW(QW), .RW(RW), .QP_W(QP_W), .N_BLK(N_BLK),
           .CHROMA_FIRST(CHROMA_FIRST), .CMD_W(CMD_W), .WR_CMD(WR_CMD),
           .REL_ADDR(REL_ADDR), .SELF_ADDR(SELF_ADDR)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .rxData(rxData), .qData(qData),
    .iData(iData), .txFull(txFull), .slotFree(slotFree),
    .smpValid(smpValid), .smpData(smpData), .parLoad(parLoad), .parQp(parQp),
    .parIntra(parIntra), .parChroma(parChroma), .txWe(txWe), .txAv(txAv),
    .txComm(txComm), .txData(txData));
endmodule

// File: tb/trn_accel_wrap_tb_top.sv
`timescale 1ns/1ps
module trn_accel_wrap_tb_top;
  localparam int NB = 6, BS = 64, NS = NB * BS, NWORDS = 400, NJ = 5;
  localparam logic [31:0] REL = 32'h0000_0F00, SELF = 32'h0300_0000;
  localparam logic [4:0] WR = 5'd2;
  // [10:6] step, [5] intra, [4:3] pattern, [2:1] full mode, [0] stray request
  localparam logic [10:0] VEC [NJ] = '{
    {5'd1,  1'b1, 2'd2, 2'd0, 1'b0},
    {5'd7,  1'b0, 2'd2, 2'd1, 1'b0},
    {5'd31, 1'b0, 2'd1, 2'd2, 1'b1},
    {5'd12, 1'b1, 2'd3, 2'd1, 1'b0},
    {5'd0,  1'b0, 2'd0, 2'd0, 1'b0}
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic [31:0] rxData = '0; logic rxAv = 1'b0, rxEmpty = 1'b1, rxRe;
  logic [31:0] txData; logic txAv, txWe, txFull = 1'b0; logic [4:0] txComm;
  logic smpValid, parLoad, parIntra, parChroma; logic [31:0] smpData; logic [4:0] parQp;
  logic qValid = 1'b0, iValid = 1'b0, qReady, iReady;
  logic [11:0] qData = '0; logic [8:0] iData = '0;

  always #2.5 clk = ~clk;

  trn_accel_wrap dut_i (.clk(clk), .rstN(rstN), .rxData(rxData), .rxAv(rxAv),
    .rxEmpty(rxEmpty), .rxRe(rxRe), .txData(txData), .txAv(txAv), .txComm(txComm),
    .txWe(txWe), .txFull(txFull), .smpValid(smpValid), .smpData(smpData),
    .parLoad(parLoad), .parQp(parQp), .parIntra(parIntra), .parChroma(parChroma),
    .qValid(qValid), .qData(qData), .qReady(qReady), .iValid(iValid),
    .iData(iData), .iReady(iReady));

  int checks = 0, errors = 0, cyc = 0, fullMode = 0;
  logic [37:0] txLog [512];
  logic [15:0] smpLog [NS];
  logic [6:0] parLog [8];
  int parAt [8];
  int txCnt = 0, smpCnt = 0, parCnt = 0;
  logic holdPend = 1'b0, holdAv; logic [31:0] holdData;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL R5 watchdog actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
    #1;
    case (fullMode)
      1: txFull = (cyc % 3 == 0);
      2: txFull = (cyc % 11 < 4);
      default: txFull = 1'b0;
    endcase
  end

  always @(negedge clk) begin
    if (parLoad) begin
      if (parCnt < 8) begin parLog[parCnt] = {parQp, parIntra, parChroma}; parAt[parCnt] = smpCnt; end
      parCnt++;
    end
    if (smpValid) begin
      if (smpCnt < NS) begin smpLog[smpCnt] = smpData[15:0]; smpLog[smpCnt+1] = smpData[31:16]; end
      smpCnt += 2;
    end
    if (txWe && !txFull) begin
      if (txCnt < 512) txLog[txCnt] = {txAv, txComm, txData};
      txCnt++;
    end
    if (holdPend && rstN)  // R9 pending word held
      chk(txWe && txData == holdData && txAv == holdAv, "R9", "held word",
          {31'b0, txAv, txData}, {31'b0, holdAv, holdData});
    holdPend = txWe && txFull; holdData = txData; holdAv = txAv;
  end

  function automatic int sGen(int pat, int i);
    int b = i / BS, k = i % BS;
    case (pat)
      0: return 0;
      1: return (b % 2 == 1) ? 0 : ((i * 37) % 200) - 100;
      2: return (k == 0) ? -200 + b * 50 : 0;
      default: return ((i * 53) % 512) - 256;
    endcase
  endfunction
  function automatic logic [11:0] qf(int s);
    int v = s >>> 2; return v[11:0];
  endfunction
  function automatic logic [15:0] qWide(int s, bit intra, int k);
    logic [11:0] q = qf(s);
    if (intra && k == 0) return {4'b0, q};
    return {{4{q[11]}}, q};
  endfunction
  function automatic logic [15:0] rWide(int s);
    logic [8:0] r = s[8:0]; return {{7{r[8]}}, r};
  endfunction
  function automatic logic [31:0] retQ(int j); return 32'h100 + j * 4; endfunction
  function automatic logic [31:0] retI(int j); return 32'h200 + j * 4; endfunction

  task automatic putWord(input bit av, input logic [31:0] d);
    @(negedge clk); rxEmpty = 1'b0; rxAv = av; rxData = d;
  endtask
  task automatic rxIdle();
    @(negedge clk); rxEmpty = 1'b1; rxAv = 1'b0;
  endtask

  task automatic sendJob(input int j);
    logic [10:0] v = VEC[j];
    putWord(1'b1, SELF);
    putWord(1'b0, retQ(j));
    putWord(1'b0, retI(j));
    putWord(1'b0, {26'b0, v[5], v[10:6]});
    for (int w = 0; w < NS / 2; w++) begin
      if (w % 50 == 17) rxIdle();
      putWord(1'b0, {16'(sGen(int'(v[4:3]), 2*w+1)), 16'(sGen(int'(v[4:3]), 2*w))});
    end
    rxIdle();
    if (v[0]) begin  // R10 stray request during transmission
      putWord(1'b1, SELF); putWord(1'b0, 32'h44); putWord(1'b0, 32'h48);
      putWord(1'b0, 32'h21);
      for (int w = 0; w < 8; w++) putWord(1'b0, 32'h1234_5678);
      rxIdle();
    end
  endtask

  task automatic drvResults(input int j);
    int pat = int'(VEC[j][4:3]);
    for (int b = 0; b < NB; b++)
      for (int st = 0; st < 2; st++)
        for (int k = 0; k < BS; k++) begin
          int s = sGen(pat, b * BS + k);
          while (smpCnt < (b + 1) * BS) @(negedge clk);
          @(negedge clk);
          qValid = (st == 0); iValid = (st == 1);
          qData = qf(s); iData = s[8:0];
          while (!(st == 0 ? qReady : iReady)) @(negedge clk);
        end
    @(negedge clk); qValid = 1'b0; iValid = 1'b0;
  endtask

  task automatic verifyJob(input int j);
    logic [10:0] v = VEC[j];
    bit intra = v[5]; int pat = int'(v[4:3]);
    int w = 0, bad = 0; logic [5:0] cbp = '0; logic [37:0] e;
    chk(txCnt == NWORDS, "R5", "word count", 64'(txCnt), 64'(NWORDS));
    for (int i = 0; i < NS; i++) if (smpLog[i] !== 16'(sGen(pat, i))) bad++;
    chk(bad == 0, "R3", "sample mismatches", 64'(bad), 0);
    chk(smpCnt == NS, "R10", "sample count", 64'(smpCnt), 64'(NS));
    chk(parCnt == NB, "R4", "param loads", 64'(parCnt), 64'(NB));
    for (int b = 0; b < NB; b++) begin
      chk(parLog[b] == {v[10:6], intra, 1'(b >= 4)} && parAt[b] == b * BS, "R4",
          "block params", {25'b0, parLog[b], 32'(parAt[b])}, {25'b0, v[10:6], intra, 1'(b >= 4), 32'(b * BS)});
      for (int k = 0; k < BS; k++)
        if (qf(sGen(pat, b * BS + k)) != 0 && !(intra && k == 0)) cbp[b] = 1'b1;
    end
    for (int b = 0; b < NB; b++)
      for (int st = 0; st < 2; st++) begin
        e = {1'b1, WR, st == 0 ? retQ(j) : retI(j)};
        chk(txLog[w] == e, b == 0 ? "R2" : "R5", "address word", 64'(txLog[w]), 64'(e)); w++;
        for (int k = 0; k < BS; k += 2) begin
          int i = b * BS + k;
          if (st == 0) e = {1'b0, WR, qWide(sGen(pat, i + 1), intra, k + 1), qWide(sGen(pat, i), intra, k)};
          else e = {1'b0, WR, rWide(sGen(pat, i + 1)), rWide(sGen(pat, i))};
          chk(txLog[w] == e, "R6", "result word", 64'(txLog[w]), 64'(e)); w++;
        end
      end
    e = {1'b1, WR, retQ(j)};
    chk(txLog[w] == e, "R7", "pattern address", 64'(txLog[w]), 64'(e)); w++;
    e = {1'b0, WR, 26'b0, cbp};
    chk(txLog[w] == e, "R7", "pattern word", 64'(txLog[w]), 64'(e)); w++;
    e = {1'b1, WR, REL};
    chk(txLog[w] == e, "R8", "release address", 64'(txLog[w]), 64'(e)); w++;
    e = {1'b0, WR, SELF};
    chk(txLog[w] == e, "R8", "release word", 64'(txLog[w]), 64'(e));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!txWe && !smpValid && !parLoad && !qReady && !iReady, "R1", "reset outputs",
        {59'b0, txWe, smpValid, parLoad, qReady, iReady}, 0);
    chk(rxRe == 1'b0, "R1", "read enable idle", 64'(rxRe), 0);
    rxEmpty = 1'b0; #1;
    chk(rxRe == 1'b1, "R1", "read enable follows", 64'(rxRe), 1);
    rxEmpty = 1'b1;
    @(negedge clk); rstN = 1'b1;
    for (int j = 0; j < NJ; j++) begin
      int t = 0;
      txCnt = 0; smpCnt = 0; parCnt = 0;
      fullMode = int'(VEC[j][2:1]);
      fork
        sendJob(j);
        drvResults(j);
      join
      while (txCnt < NWORDS && t < 20000) begin @(negedge clk); t++; end
      repeat (6) @(negedge clk);
      fullMode = 0;
      verifyJob(j);
    end
    repeat (3) @(negedge clk);
    chk(!txWe && !smpValid, "R10", "idle after last release", {62'b0, txWe, smpValid}, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule